// File: doc/BRIEF.md
# IO Virtual Address Translator

This block turns IO virtual addresses presented by a device into physical addresses. Each page of the translation window has a 64-bit entry in a directory table held in memory. A four-entry fully associative cache of recent entries sits in front of that table. A request that hits the cache is answered in one cycle. A request that misses fetches its entry through a memory read port with a valid/ready request and a response of variable latency.

A small write-only register port sets up the translation:

- the window base, with an enable flag in bit 0;
- the window mask;
- a two-bit page-size code;
- the directory base.

The same port takes a purge word, which invalidates cached entries over an address range. Software normally sets the window to 1 GiB and uses its upper half as the aperture. Writing zero to the base register turns translation off.

Top module: `iova_xlate`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o and mem_req_valid_o are 0. The cache holds no entries, so the first request in the window causes a memory read.
- R2: The page-size register is selected by reg_sel_i=2 and uses data bits [1:0]. Code 0 selects a page shift of 12, code 1 selects 13, code 2 selects 14 and code 3 selects 16.
- R3: The window-base register is selected by reg_sel_i=0, and bit 0 of the written value is the enable. The base is the written value with bit 0 cleared. The mask register is selected by reg_sel_i=1. A request is in the window only when the enable is set and (iova AND mask) equals the base. Any other request is answered one cycle after acceptance with rsp_err_o=1 and rsp_pa_o=0, and it causes no memory read.
- R4: After zero is written to the window-base register, every request is answered with an error and causes no memory read.
- R5: The directory base is selected by reg_sel_i=3. On a miss, exactly one read is issued, at address directory base + ((iova − window base) >> shift) × 8.
- R6: A valid entry gives rsp_pa_o = entry[ADDR_W-1:0] OR (iova AND (2^shift − 1)), with rsp_err_o=0.
- R7: An entry with bit 63 clear gives rsp_err_o=1 and rsp_pa_o=0. The entry is not cached, so repeating the request reads memory again.
- R8: A request whose page is cached is answered in the cycle after acceptance, and it causes no memory read.
- R9: The cache holds 4 pages and replaces them in round-robin order. After five distinct pages are filled, the first of them is evicted and the other four still hit.
- R10: A purge word is written with reg_sel_i=4. Bits [5:0] hold log2 of the range length and the bits above them hold the range base. Every cached page that overlaps the range is invalidated, and all other pages stay cached.
- R11: Any write to the page-size register or the directory base invalidates the whole cache.
- R12: mem_req_addr_o stays stable while mem_req_valid_o waits for mem_req_ready_i. Latency on both the request and the response may vary. No new request is accepted while a fetch is outstanding.
- R13: If an invalidation (a flush or a purge) happens while a fetch is outstanding, the response is still returned, but the fetched entry is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select: 0 base, 1 mask, 2 page code, 3 directory base, 4 purge |
| reg_wdata_i | input | 64 | Register write data |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Translation request accepted when high |
| req_iova_i | input | ADDR_W | IO virtual address |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Response is a fault |
| rsp_pa_o | output | ADDR_W | Physical address, zero on a fault |
| mem_req_valid_o | output | 1 | Directory read request valid |
| mem_req_ready_i | input | 1 | Directory read request accepted |
| mem_req_addr_o | output | ADDR_W | Directory entry address |
| mem_rsp_valid_i | input | 1 | Directory read data valid |
| mem_rsp_data_i | input | 64 | Directory entry: bit 63 valid, low bits page address |

## Verification
The checks assume the following about the environment:

- It answers each accepted read with exactly one data beat.
- It never raises mem_rsp_valid_i while no read is outstanding.
- It keeps req_valid_i and req_iova_i steady until the request is taken.

Under these assumptions the checks require that:

- the fetch address holds still;
- no request is taken during a fetch;
- at most one cache way matches;
- every response follows either an accepted request or returned read data.

The bench's memory model serves one read at a time, with programmable ready and data delays. The bench raises a request only when it sees ready, and it drops the request after one cycle. Configuration writes during a fetch come only from the invalidation test, and that test waits for the response.

// File: rtl/iova_xlate_pkg.sv
package iova_xlate_pkg;

  typedef enum logic [2:0] {
    SEL_WBASE = 3'd0,
    SEL_WMASK = 3'd1,
    SEL_PCODE = 3'd2,
    SEL_DBASE = 3'd3,
    SEL_PURGE = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT
  } walk_st_e;

  // 32 KiB has no code
  function automatic logic [4:0] code_to_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd12;
      2'd1:    return 5'd13;
      2'd2:    return 5'd14;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/iova_xlate_cfg.sv
module iova_xlate_cfg
  import iova_xlate_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LOG_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [63:0]       wdata_i,
  output logic [ADDR_W-1:0] win_base_o,
  output logic              win_en_o,
  output logic [ADDR_W-1:0] win_mask_o,
  output logic [4:0]        shift_o,
  output logic [ADDR_W-1:0] dir_base_o,
  output logic              flush_o,
  output logic              purge_o,
  output logic [ADDR_W-1:0] purge_base_o,
  output logic [LOG_W-1:0]  purge_log_o
);

  logic [ADDR_W-1:0] wbase_q, wmask_q, dbase_q;
  logic [1:0]        code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbase_q <= '0;
      wmask_q <= '0;
      dbase_q <= '0;
      code_q  <= '0;
    end else if (we_i) begin
      case (sel_i)
        SEL_WBASE: wbase_q <= wdata_i[ADDR_W-1:0];
        SEL_WMASK: wmask_q <= wdata_i[ADDR_W-1:0];
        SEL_PCODE: code_q  <= wdata_i[1:0];
        SEL_DBASE: dbase_q <= wdata_i[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign win_en_o     = wbase_q[0];
  assign win_base_o   = {wbase_q[ADDR_W-1:1], 1'b0};
  assign win_mask_o   = wmask_q;
  assign dir_base_o   = dbase_q;
  assign shift_o      = code_to_shift(code_q);
  assign flush_o      = we_i && (sel_i == SEL_PCODE || sel_i == SEL_DBASE);
  assign purge_o      = we_i && (sel_i == SEL_PURGE);
  assign purge_base_o = {wdata_i[ADDR_W-1:LOG_W], {LOG_W{1'b0}}};
  assign purge_log_o  = wdata_i[LOG_W-1:0];

endmodule

// File: rtl/iova_xlate_addr.sv
module iova_xlate_addr #(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] iova_i,
  input  logic [ADDR_W-1:0] win_base_i,
  input  logic              win_en_i,
  input  logic [ADDR_W-1:0] win_mask_i,
  input  logic [4:0]        shift_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  output logic              in_win_o,
  output logic [ADDR_W-1:0] off_mask_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [ADDR_W-1:0] ent_addr_o
);

  localparam logic [ADDR_W-1:0] ONES = '1;

  logic [ADDR_W-1:0] rel, idx;

  assign in_win_o   = win_en_i && ((iova_i & win_mask_i) == win_base_i);
  assign off_mask_o = ~(ONES << shift_i);
  assign tag_o      = iova_i & ~off_mask_o;
  assign rel        = iova_i - win_base_i;
  assign idx        = rel >> shift_i;
  assign ent_addr_o = dir_base_i + (idx << 3);

endmodule

// File: rtl/iova_xlate_tlb.sv
module iova_xlate_tlb #(
  parameter int ADDR_W  = 48,
  parameter int ENTRIES = 4,
  parameter int LOG_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  lk_tag_i,
  output logic               hit_o,
  output logic [ADDR_W-1:0]  hit_page_o,
  output logic [ENTRIES-1:0] hit_vec_o,
  input  logic               fill_i,
  input  logic [ADDR_W-1:0]  fill_tag_i,
  input  logic [ADDR_W-1:0]  fill_page_i,
  input  logic               flush_i,
  input  logic               purge_i,
  input  logic [ADDR_W-1:0]  purge_base_i,
  input  logic [LOG_W-1:0]   purge_log_i,
  input  logic [ADDR_W-1:0]  off_mask_i
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W-1:0] ONES = '1;

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  page_q [ENTRIES];
  logic [ENTRIES-1:0] purge_hit;
  logic [IDX_W-1:0]   ptr_q;
  logic [ADDR_W-1:0]  span;

  // range overlaps page: compare above the wider of range and page
  assign span = ~(ONES << purge_log_i) | off_mask_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign hit_vec_o[g] = valid_q[g] && (tag_q[g] == lk_tag_i);
    assign purge_hit[g] = (tag_q[g] & ~span) == (purge_base_i & ~span);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        page_q[g]  <= '0;
      end else if (flush_i || (purge_i && purge_hit[g])) begin
        valid_q[g] <= 1'b0;
      end else if (fill_i && ptr_q == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= fill_tag_i;
        page_q[g]  <= fill_page_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (fill_i) ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    hit_page_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec_o[i]) hit_page_o = hit_page_o | page_q[i];
  end

  assign hit_o = |hit_vec_o;

endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import iova_xlate_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int ENTRIES = 4,
  parameter int LOG_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [63:0]       reg_wdata_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_iova_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [ADDR_W-1:0] rsp_pa_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [63:0]       mem_rsp_data_i
);

  logic [ADDR_W-1:0] win_base, win_mask, dir_base, purge_base;
  logic              win_en, flush_all, purge_v;
  logic [4:0]        pg_shift;
  logic [LOG_W-1:0]  purge_log;

  logic              in_win;
  logic [ADDR_W-1:0] off_mask, vpn_tag, ent_addr;

  logic               tlb_hit;
  logic [ADDR_W-1:0]  tlb_page;
  logic [ENTRIES-1:0] tlb_hit_vec;
  logic               tlb_fill;

  walk_st_e          st_q;
  logic [ADDR_W-1:0] iova_q, tag_q, off_q, addr_q;
  logic              stale_q;
  logic              rsp_valid_q, rsp_err_q;
  logic [ADDR_W-1:0] rsp_pa_q;

  logic accept, inval_now, ent_ok;
  logic [ADDR_W-1:0] ent_page;

  iova_xlate_cfg #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .win_base_o  (win_base),
    .win_en_o    (win_en),
    .win_mask_o  (win_mask),
    .shift_o     (pg_shift),
    .dir_base_o  (dir_base),
    .flush_o     (flush_all),
    .purge_o     (purge_v),
    .purge_base_o(purge_base),
    .purge_log_o (purge_log)
  );

  iova_xlate_addr #(.ADDR_W(ADDR_W)) u_addr (
    .iova_i    (req_iova_i),
    .win_base_i(win_base),
    .win_en_i  (win_en),
    .win_mask_i(win_mask),
    .shift_i   (pg_shift),
    .dir_base_i(dir_base),
    .in_win_o  (in_win),
    .off_mask_o(off_mask),
    .tag_o     (vpn_tag),
    .ent_addr_o(ent_addr)
  );

  iova_xlate_tlb #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .LOG_W(LOG_W)) u_tlb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_tag_i    (vpn_tag),
    .hit_o       (tlb_hit),
    .hit_page_o  (tlb_page),
    .hit_vec_o   (tlb_hit_vec),
    .fill_i      (tlb_fill),
    .fill_tag_i  (tag_q),
    .fill_page_i (ent_page),
    .flush_i     (flush_all),
    .purge_i     (purge_v),
    .purge_base_i(purge_base),
    .purge_log_i (purge_log),
    .off_mask_i  (off_mask)
  );

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign inval_now   = flush_all || purge_v;
  assign ent_ok      = mem_rsp_data_i[63];
  assign ent_page    = mem_rsp_data_i[ADDR_W-1:0];
  // an invalidation seen during the walk may cover this page: do not cache it
  assign tlb_fill    = (st_q == ST_WAIT) && mem_rsp_valid_i && ent_ok && !stale_q && !inval_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      iova_q      <= '0;
      tag_q       <= '0;
      off_q       <= '0;
      addr_q      <= '0;
      stale_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_pa_q    <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (inval_now) stale_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (!in_win) begin
              rsp_valid_q <= 1'b1;
              rsp_err_q   <= 1'b1;
              rsp_pa_q    <= '0;
            end else if (tlb_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_err_q   <= 1'b0;
              rsp_pa_q    <= tlb_page | (req_iova_i & off_mask);
            end else begin
              st_q    <= ST_FETCH;
              iova_q  <= req_iova_i;
              tag_q   <= vpn_tag;
              off_q   <= off_mask;
              addr_q  <= ent_addr;
              stale_q <= inval_now;
            end
          end
        end
        ST_FETCH: begin
          if (mem_req_ready_i) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid_i) begin
            st_q        <= ST_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= !ent_ok;
            rsp_pa_q    <= ent_ok ? (ent_page | (iova_q & off_q)) : '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (st_q == ST_FETCH);
  assign mem_req_addr_o  = addr_q;
  assign rsp_valid_o     = rsp_valid_q;
  assign rsp_err_o       = rsp_err_q;
  assign rsp_pa_o        = rsp_pa_q;

endmodule

// File: rtl/iova_xlate_chk.sv
module iova_xlate_chk #(
  parameter int ADDR_W  = 48,
  parameter int ENTRIES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               rsp_valid_o,
  input logic               rsp_err_o,
  input logic [ADDR_W-1:0]  rsp_pa_o,
  input logic               mem_req_valid_o,
  input logic               mem_req_ready_i,
  input logic [ADDR_W-1:0]  mem_req_addr_o,
  input logic               mem_rsp_valid_i,
  input logic [ENTRIES-1:0] hit_vec
);

  // R12
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R12
  no_accept_in_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  // R3
  fault_zero_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_err_o |-> rsp_pa_o == '0);

  // R8
  rsp_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o) || $past(mem_rsp_valid_i));

  // R9
  single_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

endmodule

bind iova_xlate iova_xlate_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_err_o      (rsp_err_o),
  .rsp_pa_o       (rsp_pa_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .hit_vec        (tlb_hit_vec)
);

// File: tb/iova_xlate_tb.sv
module iova_xlate_tb;
  localparam int AW = 48;
  localparam logic [AW-1:0] WBASE = 48'h4000_0000;
  localparam logic [AW-1:0] DBASE = 48'h10_0000;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_sel = 0;
  logic [63:0] reg_wdata = 0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_iova = 0;
  logic rsp_valid, rsp_err;
  logic [AW-1:0] rsp_pa;
  logic mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  int nchk = 0, nfail = 0, reads = 0;
  int ready_dly = 0, rsp_dly = 0;
  logic [AW-1:0] last_addr = 0, bad_addr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iova_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_iova_i(req_iova),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_pa_o(rsp_pa),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready), .mem_req_addr_o(mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data)
  );

  function automatic logic [AW-1:0] page_of(logic [AW-1:0] a);
    return {1'b1, 7'b0, a[22:3], 20'h0};
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] iova, int sh);
    return DBASE + (((iova - WBASE) >> sh) << 3);
  endfunction

  function automatic logic [AW-1:0] exp_pa(logic [AW-1:0] iova, int sh);
    return page_of(exp_addr(iova, sh)) | (iova & ((48'h1 << sh) - 1));
  endfunction

  // memory model: one read at a time, programmable delays
  initial begin
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (ready_dly) @(negedge clk);
        mem_req_ready = 1;
        last_addr = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 0;
        reads++;
        repeat (rsp_dly) @(negedge clk);
        mem_rsp_valid = 1;
        mem_rsp_data = {(last_addr != bad_addr), 15'b0, page_of(last_addr)};
        @(negedge clk);
        mem_rsp_valid = 0;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic do_req(logic [AW-1:0] iova, output logic err, output logic [AW-1:0] pa,
                        output int n, output bit rdy_seen);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_iova = iova;
    @(negedge clk);
    req_valid = 0;
    n = 1; rdy_seen = 0;
    while (!rsp_valid && n < 300) begin
      if (req_ready) rdy_seen = 1;
      @(negedge clk);
      n++;
    end
    err = rsp_err; pa = rsp_pa;
  endtask

  // expect a hit (one cycle, no read) or a miss (one read) with a good translation
  task automatic xl(string req, logic [AW-1:0] iova, int sh, bit hit);
    logic e; logic [AW-1:0] p; int n, r0; bit rs;
    r0 = reads;
    do_req(iova, e, p, n, rs);
    chk(req, {63'b0, e}, 64'd0);
    chk(req, 64'(p), 64'(exp_pa(iova, sh)));
    chk(req, 64'(reads - r0), hit ? 64'd0 : 64'd1);
    if (hit) chk(req, 64'(n), 64'd1);
    else chk(req, 64'(last_addr), 64'(exp_addr(iova, sh)));
  endtask

  task automatic fault(string req, logic [AW-1:0] iova, int nreads);
    logic e; logic [AW-1:0] p; int n, r0; bit rs;
    r0 = reads;
    do_req(iova, e, p, n, rs);
    chk(req, {63'b0, e}, 64'd1);
    chk(req, 64'(p), 64'd0);
    chk(req, 64'(reads - r0), 64'(nreads));
  endtask

  task automatic t_reset;
    chk("R1 ready", {63'b0, req_ready}, 64'd1);
    chk("R1 rsp", {63'b0, rsp_valid}, 64'd0);
    chk("R1 mem", {63'b0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_basic; // R1 R5 R6 R12
    logic e; logic [AW-1:0] p; int n, r0; bit rs;
    ready_dly = 2; rsp_dly = 3;
    r0 = reads;
    do_req(48'h4000_1234, e, p, n, rs);
    chk("R1 first miss reads", 64'(reads - r0), 64'd1);
    chk("R5 entry addr", 64'(last_addr), 64'(exp_addr(48'h4000_1234, 12)));
    chk("R6 pa", 64'(p), 64'(exp_pa(48'h4000_1234, 12)));
    chk("R6 err", {63'b0, e}, 64'd0);
    chk("R12 no accept in walk", {63'b0, rs}, 64'd0);
    ready_dly = 0; rsp_dly = 1;
  endtask

  task automatic t_hit;
    xl("R8 hit same page", 48'h4000_1ABC, 12, 1);
  endtask

  task automatic t_window;
    fault("R3 below window", 48'h3FFF_F000, 0);
    fault("R3 above window", 48'h8000_0000, 0);
  endtask

  task automatic t_invalid;
    bad_addr = exp_addr(48'h4000_5000, 12);
    fault("R7 invalid entry", 48'h4000_5000, 1);
    fault("R7 invalid not cached", 48'h4000_5000, 1);
    bad_addr = 0;
  endtask

  task automatic t_rr;
    wr(3'd2, 64'd0); // R11 flush
    for (int k = 0; k < 5; k++) xl("R9 fill", 48'h4001_0000 + 48'(k) * 48'h1000, 12, 0);
    for (int k = 1; k < 5; k++) xl("R9 still cached", 48'h4001_0000 + 48'(k) * 48'h1000, 12, 1);
    xl("R9 oldest evicted", 48'h4001_0000, 12, 0);
  endtask

  task automatic t_purge;
    wr(3'd3, 64'(DBASE));
    xl("R10 fill p0", 48'h4002_0000, 12, 0);
    xl("R10 fill p1", 48'h4002_1000, 12, 0);
    xl("R10 fill p2", 48'h4003_0000, 12, 0);
    wr(3'd4, 64'h4002_000D); // 8 KiB at 0x4002_0000
    xl("R10 outside range kept", 48'h4003_0000, 12, 1);
    xl("R10 p0 purged", 48'h4002_0000, 12, 0);
    xl("R10 p1 purged", 48'h4002_1000, 12, 0);
    wr(3'd4, 64'h4003_0046); // 64 B inside p2
    xl("R10 partial overlap purged", 48'h4003_0000, 12, 0);
  endtask

  task automatic t_flush;
    xl("R11 fill", 48'h4006_0000, 12, 0);
    xl("R11 cached", 48'h4006_0000, 12, 1);
    wr(3'd2, 64'd0);
    xl("R11 code write flushes", 48'h4006_0000, 12, 0);
    wr(3'd3, 64'(DBASE));
    xl("R11 dbase write flushes", 48'h4006_0000, 12, 0);
  endtask

  task automatic t_sizes;
    for (int c = 1; c < 4; c++) begin
      int sh;
      sh = (c == 3) ? 16 : 12 + c;
      wr(3'd2, 64'(c));
      xl("R2 page code miss", 48'h4567_89AB, sh, 0);
      xl("R2 page span", 48'h4567_C9AB, sh, c == 3);
    end
    wr(3'd2, 64'd0);
  endtask

  task automatic t_disable;
    xl("R4 prefill", 48'h4007_0000, 12, 0);
    wr(3'd0, 64'd0);
    fault("R4 disabled", 48'h4007_0000, 0);
    wr(3'd0, 64'(WBASE));
    fault("R3 enable bit clear", 48'h4007_0000, 0);
    wr(3'd0, 64'(WBASE) | 64'd1);
    xl("R3 re-enabled", 48'h4007_0000, 12, 1);
  endtask

  task automatic t_stale;
    logic e; logic [AW-1:0] p; int n, r0; bit rs;
    rsp_dly = 10;
    r0 = reads;
    fork
      do_req(48'h4008_0010, e, p, n, rs);
      begin repeat (4) @(negedge clk); wr(3'd4, 64'd40); end
    join
    chk("R13 response kept", 64'(p), 64'(exp_pa(48'h4008_0010, 12)));
    chk("R13 response err", {63'b0, e}, 64'd0);
    rsp_dly = 1;
    do_req(48'h4008_0010, e, p, n, rs);
    chk("R13 not cached", 64'(reads - r0), 64'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    wr(3'd0, 64'(WBASE) | 64'd1);
    wr(3'd1, 64'hFFFF_C000_0000);
    wr(3'd3, 64'(DBASE));
    wr(3'd2, 64'd0);
    t_basic();
    t_hit();
    t_window();
    t_invalid();
    t_rr();
    t_purge();
    t_flush();
    t_sizes();
    t_disable();
    t_stale();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule